// File: doc/BRIEF.md
# Linked-List Descriptor Loader

This block is the end-of-transfer sequencer for a single DMA channel. Each time the element mover finishes one element it pulses a decrement request. The loader lowers the 12-bit element count held in the low bits of the control word and hands the updated registers back to the channel register file with a one-cycle update strobe.

When that decrement takes the count to zero, the loader chains to the next descriptor or shuts the channel down. With a nonzero link pointer it fetches a four-word descriptor from memory, one read at a time, over a request/valid read port. The source word is read first, then the destination, then the control word, and the new link pointer last. Until that final read the old pointer is still the base address for every fetch. With a zero link pointer the channel enable is cleared. The end of the sequence is marked by a done pulse. A terminal-count interrupt pulse comes with it when bit 31 of the control word that is in force after the reload is set. A read error abandons the fetch, disables the channel and raises an error-interrupt pulse in place of the terminal-count pulse.

Top module: `desc_seq`

## Requirements
- R1: A decrement accepted while the count in control bits [11:0] is 2 or more is reported one cycle later by `upd_o`. In that report `ctrl_o` keeps bits [31:12], holds the count minus one in bits [11:0], and source, destination and link pass through unchanged. `en_o` is 1 and `done_o` stays low.
- R2: A decrement is ignored when `en_i` is low or the count is zero. In that case `upd_o` and `rd_req_o` stay low.
- R3: A decrement from count 1 with a zero link pointer is reported one cycle later with `upd_o` and `done_o`. In that report `en_o` is 0, `ctrl_o[11:0]` is 0, and no read is issued.
- R4: A decrement from count 1 with a nonzero link pointer L issues four reads, to L+0, L+4, L+12 and L+8 in that order. Each `rd_req_o` is a one-cycle pulse, and the next request rises only in the cycle after `rd_valid_i` is sampled.
- R5: The fetched words are mapped as follows: L+0 goes to `src_o`, L+4 to `dst_o`, L+12 to `ctrl_o` and L+8 to `link_o`. `rd_data_i[7:0]` is the byte at the lowest address. One cycle after the last valid, `upd_o` and `done_o` pulse with `en_o` at 1.
- R6: `tc_irq_o` pulses together with `done_o` exactly when bit 31 of the resulting control word is 1. That word is the fetched control word after a reload, or the current control word when the link is zero. `tc_irq_o` never pulses without `done_o`.
- R7: `busy_o` is high from the cycle after an accepted decrement through the report cycle. A decrement presented while `busy_o` is high is ignored.
- R8: A read returned with `rd_err_i` high together with `rd_valid_i` ends the fetch. No further request is issued, and one cycle later `upd_o`, `done_o` and `err_irq_o` pulse with `en_o` at 0 and without `tc_irq_o`. Words fetched before the failing read are kept; the failing word is discarded.
- R9: While reset is asserted and after it is released, `rd_req_o`, `busy_o`, `upd_o`, `done_o`, `tc_irq_o`, `err_irq_o` and `en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_i | input | 1 | Element finished, decrement count |
| en_i | input | 1 | Current channel enable |
| src_i | input | 32 | Current source address |
| dst_i | input | 32 | Current destination address |
| link_i | input | 32 | Current link pointer |
| ctrl_i | input | 32 | Current control word |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read data returned |
| rd_err_i | input | 1 | Read returned with error, qualified by rd_valid_i |
| rd_data_i | input | 32 | Read data, little-endian |
| busy_o | output | 1 | Sequence in progress, decrements refused |
| upd_o | output | 1 | Updated register values valid this cycle |
| src_o | output | 32 | Updated source address |
| dst_o | output | 32 | Updated destination address |
| link_o | output | 32 | Updated link pointer |
| ctrl_o | output | 32 | Updated control word |
| en_o | output | 1 | Updated channel enable |
| done_o | output | 1 | End-of-transfer handling finished |
| tc_irq_o | output | 1 | Terminal-count interrupt pulse |
| err_irq_o | output | 1 | Descriptor read error interrupt pulse |

## Verification
The report of a plain decrement or a disable appears exactly one cycle after the edge that samples `dec_i`. In a chain, the first request is visible in that same cycle, and each following request or the final report appears one cycle after the edge that samples `rd_valid_i`. The bench drives at falling edges and checks the outputs at the falling edge that follows the expected register stage, so every check lands in the cycle where its result is due. The sweep covers enable, counts 0, 1, 2, 3 and 4095, both values of the interrupt bit, and zero and nonzero links. It varies read latency from one to three cycles and places an error on each of the four reads. While the pulses are checked, the bench also confirms that no request appears during the wait cycles.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_RPT} seq_st_e;
  // value is the word index of the field inside a descriptor
  typedef enum logic [1:0] {FLD_SRC = 2'd0, FLD_DST = 2'd1, FLD_LINK = 2'd2, FLD_CTRL = 2'd3} fld_e;
  localparam int unsigned NUM_WORDS = 4;
endpackage

// File: rtl/desc_count_dec.sv
module desc_count_dec #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 12
) (
  input  logic [DW-1:0] ctrl_i,
  output logic          cnt_zero_o,
  output logic          cnt_last_o,
  output logic [DW-1:0] ctrl_dec_o
);
  logic [CW-1:0] cnt;
  assign cnt        = ctrl_i[CW-1:0];
  assign cnt_zero_o = (cnt == '0);
  assign cnt_last_o = (cnt == CW'(1));
  assign ctrl_dec_o = {ctrl_i[DW-1:CW], cnt - CW'(1)};
endmodule

// File: rtl/desc_order.sv
module desc_order
  import desc_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 2
) (
  input  logic [SW-1:0] step_i,
  input  logic [AW-1:0] base_i,
  output fld_e          fld_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned WB = DW / 8;

  // control word before link: the old link stays the base until the end
  always_comb begin
    case (step_i)
      SW'(0):  fld_o = FLD_SRC;
      SW'(1):  fld_o = FLD_DST;
      SW'(2):  fld_o = FLD_CTRL;
      default: fld_o = FLD_LINK;
    endcase
  end

  assign addr_o = base_i + AW'(32'(fld_o) * WB);
endmodule

// File: rtl/desc_fsm.sv
module desc_fsm
  import desc_seq_pkg::*;
#(
  parameter int unsigned SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          fetch_i,
  input  logic          rd_valid_i,
  input  logic          rd_err_i,
  output seq_st_e       st_o,
  output logic [SW-1:0] step_o,
  output logic          last_step_o
);
  seq_st_e       st_q, st_d;
  logic [SW-1:0] step_q, step_d;

  assign last_step_o = (step_q == SW'(NUM_WORDS - 1));

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    case (st_q)
      ST_IDLE: if (accept_i) begin
        step_d = '0;
        st_d   = fetch_i ? ST_REQ : ST_RPT;
      end
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (rd_valid_i) begin
        if (rd_err_i || last_step_o) st_d = ST_RPT;
        else begin
          st_d   = ST_REQ;
          step_d = step_q + SW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  assign st_o   = st_q;
  assign step_o = step_q;
endmodule

// File: rtl/desc_seq.sv
module desc_seq
  import desc_seq_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned CW     = 12,
  parameter int unsigned TC_BIT = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          en_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] link_i,
  input  logic [DW-1:0] ctrl_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic          rd_err_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          upd_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [AW-1:0] link_o,
  output logic [DW-1:0] ctrl_o,
  output logic          en_o,
  output logic          done_o,
  output logic          tc_irq_o,
  output logic          err_irq_o
);
  localparam int unsigned SW = $clog2(NUM_WORDS);

  seq_st_e       st;
  logic [SW-1:0] step;
  logic          last_step;
  logic          cnt_zero, cnt_last;
  logic [DW-1:0] ctrl_dec;
  fld_e          fld;
  logic          accept, fetch, link_zero, rd_take;

  logic [AW-1:0] src_q, dst_q, link_q;
  logic [DW-1:0] ctrl_q;
  logic          en_q, term_q, tc_q, err_q;

  desc_count_dec #(.DW(DW), .CW(CW)) u_cnt (
    .ctrl_i    (ctrl_i),
    .cnt_zero_o(cnt_zero),
    .cnt_last_o(cnt_last),
    .ctrl_dec_o(ctrl_dec)
  );

  desc_order #(.AW(AW), .DW(DW), .SW(SW)) u_ord (
    .step_i(step),
    .base_i(link_q),
    .fld_o (fld),
    .addr_o(rd_addr_o)
  );

  assign link_zero = (link_i == '0);
  assign accept    = (st == ST_IDLE) && dec_i && en_i && !cnt_zero;
  assign fetch     = cnt_last && !link_zero;
  assign rd_take   = (st == ST_WAIT) && rd_valid_i;

  desc_fsm #(.SW(SW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .fetch_i    (fetch),
    .rd_valid_i (rd_valid_i),
    .rd_err_i   (rd_err_i),
    .st_o       (st),
    .step_o     (step),
    .last_step_o(last_step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      link_q <= '0;
      ctrl_q <= '0;
      en_q   <= 1'b0;
      term_q <= 1'b0;
      tc_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      src_q  <= src_i;
      dst_q  <= dst_i;
      link_q <= link_i;
      ctrl_q <= ctrl_dec;
      en_q   <= !(cnt_last && link_zero);
      term_q <= cnt_last;
      tc_q   <= cnt_last && link_zero && ctrl_i[TC_BIT];
      err_q  <= 1'b0;
    end else if (rd_take) begin
      if (rd_err_i) begin
        en_q  <= 1'b0;
        err_q <= 1'b1;
        tc_q  <= 1'b0;
      end else begin
        case (fld)
          FLD_SRC:  src_q  <= AW'(rd_data_i);
          FLD_DST:  dst_q  <= AW'(rd_data_i);
          FLD_CTRL: ctrl_q <= rd_data_i;
          default:  link_q <= AW'(rd_data_i);
        endcase
        if (last_step)
          tc_q <= (fld == FLD_CTRL) ? rd_data_i[TC_BIT] : ctrl_q[TC_BIT];
      end
    end
  end

  assign rd_req_o  = (st == ST_REQ);
  assign busy_o    = (st != ST_IDLE);
  assign upd_o     = (st == ST_RPT);
  assign done_o    = upd_o && term_q;
  assign tc_irq_o  = upd_o && tc_q;
  assign err_irq_o = upd_o && err_q;
  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign link_o    = link_q;
  assign ctrl_o    = ctrl_q;
  assign en_o      = en_q;
endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_req_o,
  input logic          busy_o,
  input logic          upd_o,
  input logic          done_o,
  input logic          en_o,
  input logic          tc_irq_o,
  input logic          err_irq_o,
  input logic [DW-1:0] ctrl_o
);
  // R4
  rd_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  // R7
  busy_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || upd_o) |-> busy_o);
  // R8
  err_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (done_o && !en_o && !tc_irq_o));
  // R6
  tc_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_irq_o |-> done_o);
  // R1
  partial_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !done_o) |-> (en_o && ctrl_o[CW-1:0] != '0));
  // R3
  disable_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !en_o && !err_irq_o) |-> (ctrl_o[CW-1:0] == '0));
endmodule

bind desc_seq desc_seq_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_req_o (rd_req_o),
  .busy_o   (busy_o),
  .upd_o    (upd_o),
  .done_o   (done_o),
  .en_o     (en_o),
  .tc_irq_o (tc_irq_o),
  .err_irq_o(err_irq_o),
  .ctrl_o   (ctrl_o)
);

// File: tb/desc_seq_tb_top.sv
module desc_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dec_i = 1'b0, en_i = 1'b0;
  logic [31:0] src_i = '0, dst_i = '0, link_i = '0, ctrl_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_valid_i = 1'b0, rd_err_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        busy_o, upd_o, en_o, done_o, tc_irq_o, err_irq_o;
  logic [31:0] src_o, dst_o, link_o, ctrl_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dec_i(dec_i), .en_i(en_i),
    .src_i(src_i), .dst_i(dst_i), .link_i(link_i), .ctrl_i(ctrl_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_err_i(rd_err_i), .rd_data_i(rd_data_i), .busy_o(busy_o), .upd_o(upd_o),
    .src_o(src_o), .dst_o(dst_o), .link_o(link_o), .ctrl_o(ctrl_o), .en_o(en_o),
    .done_o(done_o), .tc_irq_o(tc_irq_o), .err_irq_o(err_irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[4], a[30:0] ^ 31'h2A5A_5A5A};
  endfunction

  function automatic logic [31:0] step_off(input int k);
    case (k)
      0: return 32'd0;
      1: return 32'd4;
      2: return 32'd12;
      default: return 32'd8;
    endcase
  endfunction

  task automatic present(input bit en, input logic [11:0] cnt, input bit b31, input logic [31:0] l);
    en_i   = en;
    src_i  = 32'hA000_0000 + {20'd0, cnt};
    dst_i  = 32'hB000_0000 + l;
    link_i = l;
    ctrl_i = {b31, 19'h2_3456, cnt};
  endtask

  task automatic fetch(input logic [31:0] l, input int lat, input int err_idx, input bit hold_dec);
    logic [31:0] e_src, e_dst, e_link, e_ctrl;
    e_src = src_i; e_dst = dst_i; e_link = l; e_ctrl = {ctrl_i[31:12], 12'd0};
    for (int k = 0; k < 4; k++) begin
      int guard = 0;
      while (!rd_req_o && guard < 20) begin @(negedge clk); guard++; end
      chk($sformatf("R4 req step %0d seen", k), {31'd0, rd_req_o}, 32'd1);
      chk($sformatf("R4 addr step %0d", k), rd_addr_o, l + step_off(k));
      chk("R7 busy during fetch", {31'd0, busy_o}, 32'd1);
      for (int j = 0; j < lat; j++) begin
        if (hold_dec && k == 0) dec_i = 1'b1;
        @(negedge clk);
        chk("R4 no request before valid", {31'd0, rd_req_o}, 32'd0);
      end
      dec_i      = 1'b0;
      rd_valid_i = 1'b1;
      rd_data_i  = mem_word(l + step_off(k));
      rd_err_i   = (k == err_idx);
      @(negedge clk);
      rd_valid_i = 1'b0;
      rd_err_i   = 1'b0;
      if (k == err_idx) break;
      case (k)
        0: e_src  = mem_word(l);
        1: e_dst  = mem_word(l + 4);
        2: e_ctrl = mem_word(l + 12);
        default: e_link = mem_word(l + 8);
      endcase
    end
    if (err_idx < 4) begin
      chk("R8 report", {28'd0, upd_o, done_o, err_irq_o, tc_irq_o}, 32'hE);
      chk("R8 enable cleared", {31'd0, en_o}, 32'd0);
      chk("R8 no request after error", {31'd0, rd_req_o}, 32'd0);
    end else begin
      chk("R5 report", {29'd0, upd_o, done_o, en_o}, 32'h7);
      chk("R6 tc after reload", {30'd0, tc_irq_o, err_irq_o}, {30'd0, e_ctrl[31], 1'b0});
    end
    chk("R5 src", src_o, e_src);
    chk("R5 dst", dst_o, e_dst);
    chk("R5 ctrl", ctrl_o, e_ctrl);
    chk("R5 link", link_o, e_link);
    @(negedge clk);
    chk("R7 idle after report", {30'd0, upd_o, busy_o}, 32'd0);
  endtask

  task automatic run_dec(input bit en, input logic [11:0] cnt, input bit b31, input logic [31:0] l,
                         input int lat, input int err_idx, input bit hold_dec);
    @(negedge clk);
    present(en, cnt, b31, l);
    dec_i = 1'b1;
    @(negedge clk);
    dec_i = 1'b0;
    if (!en || cnt == 12'd0) begin
      chk("R2 ignored", {30'd0, upd_o, rd_req_o}, 32'd0);
      @(negedge clk);
      chk("R2 still ignored", {30'd0, upd_o, busy_o}, 32'd0);
    end else if (cnt != 12'd1) begin
      chk("R1 report", {28'd0, upd_o, done_o, en_o, tc_irq_o}, 32'hA);
      chk("R1 ctrl", ctrl_o, {ctrl_i[31:12], cnt - 12'd1});
      chk("R1 src", src_o, src_i);
      chk("R1 dst", dst_o, dst_i);
      chk("R1 link", link_o, l);
      @(negedge clk);
      chk("R7 single report", {30'd0, upd_o, busy_o}, 32'd0);
    end else if (l == 32'd0) begin
      chk("R3 report", {29'd0, upd_o, done_o, en_o}, 32'h6);
      chk("R3 count zero", {20'd0, ctrl_o[11:0]}, 32'd0);
      chk("R3 no read", {31'd0, rd_req_o}, 32'd0);
      chk("R6 tc on disable", {30'd0, tc_irq_o, err_irq_o}, {30'd0, b31, 1'b0});
      @(negedge clk);
      chk("R7 single report", {30'd0, upd_o, busy_o}, 32'd0);
    end else begin
      fetch(l, lat, err_idx, hold_dec);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] cnts [5] = '{12'd0, 12'd1, 12'd2, 12'd3, 12'hFFF};
    logic [31:0] links [3] = '{32'h0, 32'h100, 32'h110};
    repeat (2) @(negedge clk);
    chk("R9 in reset", {25'd0, rd_req_o, busy_o, upd_o, done_o, tc_irq_o, err_irq_o, en_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 after reset", {25'd0, rd_req_o, busy_o, upd_o, done_o, tc_irq_o, err_irq_o, en_o}, 32'd0);

    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 5; c++)
        for (int b = 0; b < 2; b++)
          for (int li = 0; li < 3; li++)
            run_dec(e[0], cnts[c], b[0], links[li], 1, 4, 1'b0);

    for (int lat = 1; lat <= 3; lat++)
      for (int ei = 0; ei <= 4; ei++)
        run_dec(1'b1, 12'd1, 1'b1, 32'h110, lat, ei, 1'b0);

    // R7: decrement held during the wait is refused
    run_dec(1'b1, 12'd1, 1'b0, 32'h100, 3, 4, 1'b1);
    run_dec(1'b1, 12'd1, 1'b1, 32'h110, 2, 4, 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule